// File: doc/BRIEF.md
# Word-Serial Modular Add/Subtract Unit

This block runs five arithmetic operations on multi-word operands held in a single-port scratchpad RAM: modular addition, modular subtraction, modular comparison, modular doubling (left shift by one) and plain big-integer addition. Words are 32 bits wide. Each operand sits at consecutive word addresses, with the least significant word at its pointer. The block steps through the words from low to high. Between word steps it keeps one carry or borrow bit, plus a second borrow bit for a trial subtraction of the modulus that runs alongside.

A host places the operands in the RAM. It then presents an operation code, a 6-bit length code and four 9-bit word pointers (A, B, modulus P, result C), and pulses `start`. The block latches these settings and owns the RAM port until it pulses `done`. For the modular operations, a second pass over the result runs only when it is needed: it subtracts P once (addition, doubling) or adds P once (subtraction). Comparison writes nothing and reports a 2-bit code. Big-integer addition reports a carry out of the top word on `ovf`.

Top module: `wsmod_addsub`

## Requirements
- R1: A start is accepted only while `busy` is low and only for operation codes 2 (modular add), 3 (modular subtract), 4 (compare), 5 (modular double) and 7 (big add). Any other code causes no `busy`, no `done` and no RAM access.
- R2: The length code L selects L+1 words. Word i of an operand is at address pointer+i, taken modulo 512.
- R3: Modular add writes C = A+B−P if A+B carried out of the top word or A+B ≥ P. Otherwise it writes C = A+B.
- R4: Modular subtract writes C = A−B when A ≥ B, and C = A−B+P when it borrowed.
- R5: Modular double writes C = 2A−P if 2A carried out or 2A ≥ P. Otherwise it writes C = 2A.
- R6: Compare sets `cmp_res` to 2'b00 for A = P, 2'b01 for A < P and 2'b10 for A > P. It writes nothing to RAM. `cmp_res` keeps its value until the next compare.
- R7: Big add writes C = (A+B) mod 2^(32·(L+1)) and sets `ovf` to the carry out of the top word. `ovf` is cleared when any operation is accepted and otherwise holds its value.
- R8: The RAM port makes at most one access per cycle. Read data is taken in the cycle after `mem_re`. The port is silent while the block is idle.
- R9: `busy` rises in the cycle after an accepted start. `done` is a one-cycle pulse in the cycle `busy` falls.
- R10: The first pass of modular add takes 4 cycles per word. Every other pass takes 3 cycles per word. A correction pass runs at most once, and only when R3, R4 or R5 calls for it. So `done` follows the start edge by 4w, 7w, 3w or 6w cycles.
- R11: The operation code, length and pointers are latched at the accepted start. Changes to them, and further start pulses, have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op_code | input | 3 | Operation select |
| len_code | input | 6 | Operand length minus one, in words |
| ptr_a | input | 9 | Word address of operand A |
| ptr_b | input | 9 | Word address of operand B |
| ptr_p | input | 9 | Word address of modulus P |
| ptr_c | input | 9 | Word address of result C |
| mem_re | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | 9 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cmp_res | output | 2 | Result of the last compare |
| ovf | output | 1 | Carry out of the last big add |

## Verification
The bench targets the boundaries of the correction decision, each with its own case:
- A sum exactly equal to P must become zero. A design testing "greater than" instead of "greater or equal" would leave P in C.
- Sums and doublings that carry out of the top word must still reduce. A design that ignores the carry would write a value above P.
- Subtraction with and without a borrow is checked, and its cycle count shows whether a correction pass ran when it should not have.

Compare inputs differ from P only in the low word, or in opposite directions in the top and low words. A design that scanned words in the wrong order, or let an early word's result override later ones, would report the wrong code. Further cases cover:
- pointers that wrap past address 511;
- a 64-word big add that carries out;
- clearing of the overflow flag;
- unsupported codes;
- inputs disturbed while the block is busy, where a design that reads its inputs live would corrupt the result.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef logic [2:0] op_t;

  localparam op_t OP_MADD = 3'd2;
  localparam op_t OP_MSUB = 3'd3;
  localparam op_t OP_MCMP = 3'd4;
  localparam op_t OP_MSHL = 3'd5;
  localparam op_t OP_BADD = 3'd7;

  localparam logic [1:0] CMP_EQ = 2'b00;
  localparam logic [1:0] CMP_LT = 2'b01;
  localparam logic [1:0] CMP_GT = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RM,
    ST_RY,
    ST_EX
  } seq_st_t;

  function automatic logic op_supported(input op_t o);
    return (o == OP_MADD) || (o == OP_MSUB) || (o == OP_MCMP) ||
           (o == OP_MSHL) || (o == OP_BADD);
  endfunction

endpackage

// File: rtl/wsa_word_alu.sv
module wsa_word_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          cout
);

  logic [DW:0] acc;

  // Subtract as x + ~y + !borrow_in; borrow_out is the inverted carry.
  always_comb begin
    acc  = {1'b0, x} + {1'b0, (sub ? ~y : y)} + {{DW{1'b0}}, (sub ? ~cin : cin)};
    r    = acc[DW-1:0];
    cout = sub ? ~acc[DW] : acc[DW];
  end

endmodule

// File: rtl/wsa_datapath.sv
module wsa_datapath
  import wsa_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_t           op,
  input  logic          fix_pass,
  input  logic          op_start,
  input  logic          chain_clr,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic          exec,
  input  logic          last_word,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic          need_fix,
  output logic [1:0]    cmp_res,
  output logic          ovf
);

  logic [DW-1:0] ra_q, ra_d, rb_q, rb_d;
  logic          cy_q, cy_d, tb_q, tb_d, eq_q, eq_d;
  logic [1:0]    cmp_q, cmp_d;
  logic          ovf_q, ovf_d;

  logic [DW-1:0] alu_x, alu_y, alu_r, shl_r, res, try_x, try_r;
  logic          alu_sub, alu_co, res_co, try_co, res_load, try_zero;

  // Operand routing for the main word ALU.
  always_comb begin
    alu_x   = ra_q;
    alu_y   = rdata;
    alu_sub = 1'b0;
    if (fix_pass) begin
      alu_sub = (op != OP_MSUB);
    end else begin
      if (op == OP_MADD) alu_y = rb_q;
      alu_sub = (op == OP_MSUB) || (op == OP_MCMP);
    end
  end

  wsa_word_alu #(.DW(DW)) u_main_alu (
    .x    (alu_x),
    .y    (alu_y),
    .cin  (cy_q),
    .sub  (alu_sub),
    .r    (alu_r),
    .cout (alu_co)
  );

  assign shl_r = {ra_q[DW-2:0], cy_q};

  always_comb begin
    if (!fix_pass && (op == OP_MSHL)) begin
      res    = shl_r;
      res_co = ra_q[DW-1];
    end else begin
      res    = alu_r;
      res_co = alu_co;
    end
  end

  // Trial subtraction of P running beside the main chain.
  assign try_x = (op == OP_MCMP) ? ra_q : res;

  wsa_word_alu #(.DW(DW)) u_try_alu (
    .x    (try_x),
    .y    (rdata),
    .cin  (tb_q),
    .sub  (1'b1),
    .r    (try_r),
    .cout (try_co)
  );

  assign try_zero = (try_r == '0);
  assign wdata    = res;
  assign res_load = exec && last_word && !fix_pass;

  always_comb begin
    need_fix = 1'b0;
    if (!fix_pass) begin
      if ((op == OP_MADD) || (op == OP_MSHL)) need_fix = res_co || !try_co;
      else if (op == OP_MSUB)                 need_fix = res_co;
    end
  end

  // Next-state logic.
  always_comb begin
    ra_d = cap_a ? rdata : ra_q;
    rb_d = cap_b ? rdata : rb_q;
    cy_d = cy_q;
    tb_d = tb_q;
    eq_d = eq_q;
    if (chain_clr) begin
      cy_d = 1'b0;
      tb_d = 1'b0;
      eq_d = 1'b1;
    end else if (exec) begin
      cy_d = res_co;
      tb_d = try_co;
      eq_d = eq_q && try_zero;
    end
    ovf_d = ovf_q;
    if (op_start)                            ovf_d = 1'b0;
    else if (res_load && (op == OP_BADD))    ovf_d = res_co;
    cmp_d = cmp_q;
    if (res_load && (op == OP_MCMP)) begin
      if (try_co)                  cmp_d = CMP_LT;
      else if (eq_q && try_zero)   cmp_d = CMP_EQ;
      else                         cmp_d = CMP_GT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      rb_q  <= '0;
      cy_q  <= 1'b0;
      tb_q  <= 1'b0;
      eq_q  <= 1'b1;
      cmp_q <= CMP_EQ;
      ovf_q <= 1'b0;
    end else begin
      ra_q  <= ra_d;
      rb_q  <= rb_d;
      cy_q  <= cy_d;
      tb_q  <= tb_d;
      eq_q  <= eq_d;
      cmp_q <= cmp_d;
      ovf_q <= ovf_d;
    end
  end

  assign cmp_res = cmp_q;
  assign ovf     = ovf_q;

  AST_OVF_FROM_BADD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (op == OP_BADD)); // R7
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_MCMP) |=> $stable(cmp_q)); // R6

endmodule

// File: rtl/wsa_sequencer.sv
module wsa_sequencer
  import wsa_pkg::*;
#(
  parameter int AW = 9,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_t           mode_in,
  input  logic [LW-1:0] len_in,
  input  logic [AW-1:0] pa_in,
  input  logic [AW-1:0] pb_in,
  input  logic [AW-1:0] pp_in,
  input  logic [AW-1:0] pc_in,
  input  logic          need_fix,
  output op_t           op,
  output logic          fix_pass,
  output logic          op_start,
  output logic          chain_clr,
  output logic          cap_a,
  output logic          cap_b,
  output logic          exec,
  output logic          last_word,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done
);

  seq_st_t       st_q, st_d;
  logic [LW-1:0] idx_q, idx_d, len_q;
  logic          fix_q, fix_d, done_q, done_d;
  op_t           op_q;
  logic [AW-1:0] pa_q, pb_q, pp_q, pc_q, ptr_y;
  logic          accept, three_rd, go_fix;

  assign accept   = (st_q == ST_IDLE) && start && op_supported(mode_in);
  assign three_rd = !fix_q && (op_q == OP_MADD);
  assign last_word = (idx_q == len_q);
  assign ptr_y    = (!fix_q && ((op_q == OP_MSUB) || (op_q == OP_BADD))) ? pb_q : pp_q;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    fix_d    = fix_q;
    done_d   = 1'b0;
    go_fix   = 1'b0;
    cap_a    = 1'b0;
    cap_b    = 1'b0;
    exec     = 1'b0;
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_RX;
          idx_d = '0;
          fix_d = 1'b0;
        end
      end
      ST_RX: begin
        mem_re   = 1'b1;
        mem_addr = (fix_q ? pc_q : pa_q) + AW'(idx_q);
        st_d     = three_rd ? ST_RM : ST_RY;
      end
      ST_RM: begin
        mem_re   = 1'b1;
        mem_addr = pb_q + AW'(idx_q);
        cap_a    = 1'b1;
        st_d     = ST_RY;
      end
      ST_RY: begin
        mem_re   = 1'b1;
        mem_addr = ptr_y + AW'(idx_q);
        cap_a    = !three_rd;
        cap_b    = three_rd;
        st_d     = ST_EX;
      end
      ST_EX: begin
        exec     = 1'b1;
        mem_we   = (op_q != OP_MCMP);
        mem_addr = pc_q + AW'(idx_q);
        if (last_word) begin
          if (!fix_q && need_fix) begin
            go_fix = 1'b1;
            fix_d  = 1'b1;
            idx_d  = '0;
            st_d   = ST_RX;
          end else begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_RX;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      fix_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      fix_q  <= fix_d;
      done_q <= done_d;
    end
  end

  // Configuration is captured only when an operation is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MADD;
      len_q <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pp_q  <= '0;
      pc_q  <= '0;
    end else if (accept) begin
      op_q  <= mode_in;
      len_q <= len_in;
      pa_q  <= pa_in;
      pb_q  <= pb_in;
      pp_q  <= pp_in;
      pc_q  <= pc_in;
    end
  end

  assign op        = op_q;
  assign fix_pass  = fix_q;
  assign op_start  = accept;
  assign chain_clr = accept || go_fix;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R8
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= len_q)); // R2
  AST_SINGLE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EX && fix_q && last_word) |=> (st_q == ST_IDLE)); // R10
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len_q) && $stable(op_q) && $stable(pc_q))); // R11
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_MCMP) |-> !mem_we); // R6

endmodule

// File: rtl/wsmod_addsub.sv
module wsmod_addsub
  import wsa_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 9,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_code,
  input  logic [LW-1:0] len_code,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  input  logic [AW-1:0] ptr_p,
  input  logic [AW-1:0] ptr_c,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    cmp_res,
  output logic          ovf
);

  op_t  op;
  logic fix_pass, op_start, chain_clr, cap_a, cap_b, exec, last_word, need_fix;

  wsa_sequencer #(.AW(AW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (op_code),
    .len_in    (len_code),
    .pa_in     (ptr_a),
    .pb_in     (ptr_b),
    .pp_in     (ptr_p),
    .pc_in     (ptr_c),
    .need_fix  (need_fix),
    .op        (op),
    .fix_pass  (fix_pass),
    .op_start  (op_start),
    .chain_clr (chain_clr),
    .cap_a     (cap_a),
    .cap_b     (cap_b),
    .exec      (exec),
    .last_word (last_word),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done)
  );

  wsa_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .fix_pass  (fix_pass),
    .op_start  (op_start),
    .chain_clr (chain_clr),
    .cap_a     (cap_a),
    .cap_b     (cap_b),
    .exec      (exec),
    .last_word (last_word),
    .rdata     (mem_rdata),
    .wdata     (mem_wdata),
    .need_fix  (need_fix),
    .cmp_res   (cmp_res),
    .ovf       (ovf)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9

endmodule

// File: tb/tb_wsmod_addsub.sv
module tb_wsmod_addsub;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam int LW = 6;
  localparam int BW = 2112;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [2:0]    op_code = '0;
  logic [LW-1:0] len_code = '0;
  logic [AW-1:0] ptr_a = '0, ptr_b = '0, ptr_p = '0, ptr_c = '0;
  logic          mem_re, mem_we, busy, done, ovf;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rdata_q;
  logic [1:0]    cmp_res;

  logic [DW-1:0] mem [DEPTH];
  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [DW-1:0] tb_wdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  wsmod_addsub dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .len_code(len_code),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_p(ptr_p), .ptr_c(ptr_c),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdata_q), .busy(busy), .done(done), .cmp_res(cmp_res), .ovf(ovf)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else if (tb_we) mem[tb_addr] <= tb_wdata;
    if (mem_re) rdata_q <= mem[mem_addr];
  end

  task automatic chk(input string req, input string what, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] mask(input int w);
    return (BW'(1) << (32 * w)) - BW'(1);
  endfunction

  task automatic gen(input int w, output logic [BW-1:0] v);
    v = '0;
    for (int k = 0; k < w; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      v[32*k +: 32] = seed ^ {seed[15:0], seed[31:16]};
    end
  endtask

  task automatic gen_mod(input int w, output logic [BW-1:0] p);
    gen(w, p);
    p[32*w-1] = 1'b1;
  endtask

  task automatic gen_below(input int w, input logic [BW-1:0] p, output logic [BW-1:0] a);
    gen(w, a);
    if (a >= p) a = a - p;
  endtask

  task automatic load(input logic [AW-1:0] ptr, input int w, input logic [BW-1:0] v);
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      tb_we = 1'b1;
      tb_addr = ptr + AW'(k);
      tb_wdata = v[32*k +: 32];
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [BW-1:0] fetch(input logic [AW-1:0] ptr, input int w);
    logic [BW-1:0] v;
    logic [AW-1:0] a;
    v = '0;
    for (int k = 0; k < w; k++) begin
      a = ptr + AW'(k);
      v[32*k +: 32] = mem[a];
    end
    return v;
  endfunction

  task automatic run(input logic [2:0] m, input int code, input logic [AW-1:0] pa, pb, pp, pc,
                     input bit disturb, output int cyc);
    @(negedge clk);
    op_code = m; len_code = LW'(code);
    ptr_a = pa; ptr_b = pb; ptr_p = pp; ptr_c = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "busy after start", BW'(busy), BW'(1));
    cyc = 0;
    do begin
      @(posedge clk);
      #1;
      cyc++;
      if (disturb && cyc == 2) begin
        start = 1'b1; op_code = 3'd7; len_code = 6'd1;
        ptr_a = 9'h100; ptr_b = 9'h100; ptr_p = 9'h100; ptr_c = 9'h100;
      end
      if (disturb && cyc == 3) start = 1'b0;
    end while (!done && cyc < 5000);
    if (cyc >= 5000) begin
      n_fail++;
      $display("FAIL R9 done missing: actual none expected pulse");
    end
    @(posedge clk);
    #1;
    chk("R9", "done one cycle", BW'({done, busy}), BW'(0));
  endtask

  function automatic logic [BW-1:0] ref_madd(input logic [BW-1:0] a, b, p);
    logic [BW-1:0] s;
    s = a + b;
    if (s >= p) s = s - p;
    return s;
  endfunction

  function automatic logic [BW-1:0] ref_msub(input logic [BW-1:0] a, b, p);
    return (a >= b) ? a - b : a + p - b;
  endfunction

  function automatic logic [BW-1:0] ref_shl(input logic [BW-1:0] a, p);
    logic [BW-1:0] s;
    s = a << 1;
    if (s >= p) s = s - p;
    return s;
  endfunction

  localparam logic [AW-1:0] PA = 9'h020, PB = 9'h028, PP = 9'h030, PC = 9'h038;
  localparam logic [AW-1:0] BA = 9'h088, BB = 9'h090, BC = 9'h098;

  task automatic t_reset();
    chk("R9", "reset busy/done", BW'({busy, done}), BW'(0));
    chk("R7", "reset ovf", BW'(ovf), BW'(0));
    chk("R6", "reset cmp", BW'(cmp_res), BW'(0));
    chk("R8", "reset port idle", BW'({mem_re, mem_we}), BW'(0));
  endtask

  task automatic t_invalid();
    logic [BW-1:0] sent;
    bit seen;
    gen(8, sent);
    load(PC, 8, sent);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_code = (i == 0) ? 3'd0 : (i == 1) ? 3'd1 : 3'd6;
      len_code = 6'd7; ptr_a = PA; ptr_b = PB; ptr_p = PP; ptr_c = PC;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int c = 0; c < 12; c++) begin
        @(posedge clk);
        #1;
        if (busy || done || mem_re || mem_we) seen = 1'b1;
      end
      chk("R1", "unsupported code activity", BW'(seen), BW'(0));
    end
    chk("R1", "unsupported code left C", fetch(PC, 8), sent);
  endtask

  task automatic t_madd();
    logic [BW-1:0] a, b, p;
    int cyc;
    gen_mod(8, p);
    a = 'h5; b = 'h9;
    load(PA, 8, a); load(PB, 8, b); load(PP, 8, p);
    run(3'd2, 7, PA, PB, PP, PC, 1'b0, cyc);
    chk("R3", "madd small", fetch(PC, 8), ref_madd(a, b, p));
    chk("R10", "madd no-fix latency", BW'(cyc), BW'(32));
    gen_below(8, p, a);
    b = p - a;
    load(PA, 8, a); load(PB, 8, b);
    run(3'd2, 7, PA, PB, PP, PC, 1'b0, cyc);
    chk("R3", "madd sum equal P", fetch(PC, 8), BW'(0));
    chk("R10", "madd fix latency", BW'(cyc), BW'(56));
    p = mask(2); a = p - 1; b = p - 1;
    load(PA, 2, a); load(PB, 2, b); load(PP, 2, p);
    run(3'd2, 1, PA, PB, PP, PC, 1'b0, cyc);
    chk("R3", "madd carry out", fetch(PC, 2), p - 2);
    chk("R10", "madd carry latency", BW'(cyc), BW'(14));
  endtask

  task automatic t_msub();
    logic [BW-1:0] a, b, p;
    int cyc;
    gen_mod(4, p);
    a = 'h3; b = 'h5;
    load(PA, 4, a); load(PB, 4, b); load(PP, 4, p);
    run(3'd3, 3, PA, PB, PP, PC, 1'b0, cyc);
    chk("R4", "msub borrow", fetch(PC, 4), ref_msub(a, b, p));
    chk("R10", "msub fix latency", BW'(cyc), BW'(24));
    gen_below(4, p, a); gen_below(4, p, b);
    if (a < b) begin logic [BW-1:0] t; t = a; a = b; b = t; end
    load(PA, 4, a); load(PB, 4, b);
    run(3'd3, 3, PA, PB, PP, PC, 1'b0, cyc);
    chk("R4", "msub no borrow", fetch(PC, 4), a - b);
    chk("R10", "msub no-fix latency", BW'(cyc), BW'(12));
  endtask

  task automatic t_shl();
    logic [BW-1:0] a, p;
    int cyc;
    gen_mod(3, p);
    p[0] = 1'b0;
    a = p >> 1;
    load(PA, 3, a); load(PP, 3, p);
    run(3'd5, 2, PA, PB, PP, PC, 1'b0, cyc);
    chk("R5", "double equal P", fetch(PC, 3), BW'(0));
    a = p - 1;
    load(PA, 3, a);
    run(3'd5, 2, PA, PB, PP, PC, 1'b0, cyc);
    chk("R5", "double carry out", fetch(PC, 3), ref_shl(a, p));
    a = 'h7001;
    load(PA, 3, a);
    run(3'd5, 2, PA, PB, PP, PC, 1'b0, cyc);
    chk("R5", "double small", fetch(PC, 3), BW'('hE002));
    chk("R10", "double no-fix latency", BW'(cyc), BW'(9));
  endtask

  task automatic t_cmp();
    logic [BW-1:0] a, p, sent;
    int cyc;
    gen_mod(4, p);
    p[0] = 1'b1;
    p[127:124] = 4'h8;
    p[123:96] = '0;
    gen(4, sent);
    load(PC, 4, sent); load(PP, 4, p);
    load(PA, 4, p);
    run(3'd4, 3, PA, PB, PP, PC, 1'b0, cyc);
    chk("R6", "cmp equal", BW'(cmp_res), BW'(2'b00));
    chk("R10", "cmp latency", BW'(cyc), BW'(12));
    a = p - 1;
    load(PA, 4, a);
    run(3'd4, 3, PA, PB, PP, PC, 1'b0, cyc);
    chk("R6", "cmp less in low word", BW'(cmp_res), BW'(2'b01));
    a = p + (BW'(1) << 96) - 1;
    load(PA, 4, a);
    run(3'd4, 3, PA, PB, PP, PC, 1'b0, cyc);
    chk("R6", "cmp greater in top word", BW'(cmp_res), BW'(2'b10));
    chk("R6", "cmp left C", fetch(PC, 4), sent);
  endtask

  task automatic t_badd();
    logic [BW-1:0] a, b, s, p;
    int cyc;
    a = mask(8); b = 'h1;
    load(BA, 8, a); load(BB, 8, b);
    run(3'd7, 7, BA, BB, PP, BC, 1'b0, cyc);
    chk("R7", "big add wrap", fetch(BC, 8), BW'(0));
    chk("R7", "big add carry", BW'(ovf), BW'(1));
    gen_mod(2, p);
    a = 'h4; b = 'h6;
    load(PA, 2, a); load(PB, 2, b); load(PP, 2, p);
    run(3'd2, 1, PA, PB, PP, PC, 1'b0, cyc);
    chk("R7", "ovf cleared by next start", BW'(ovf), BW'(0));
    gen(64, a); gen(64, b);
    a[2047] = 1'b1; b[2047] = 1'b1;
    load(9'h000, 64, a); load(9'h040, 64, b);
    run(3'd7, 63, 9'h000, 9'h040, PP, 9'h080, 1'b0, cyc);
    s = a + b;
    chk("R7", "64-word big add", fetch(9'h080, 64), s & mask(64));
    chk("R7", "64-word carry", BW'(ovf), BW'(s[2048]));
    chk("R2", "64-word latency", BW'(cyc), BW'(192));
  endtask

  task automatic t_wrap();
    logic [BW-1:0] a, b, p;
    int cyc;
    gen_mod(4, p);
    gen_below(4, p, a); gen_below(4, p, b);
    load(9'h1FE, 4, a); load(9'h1F0, 4, b); load(9'h1E0, 4, p);
    run(3'd2, 3, 9'h1FE, 9'h1F0, 9'h1E0, 9'h1FD, 1'b0, cyc);
    chk("R2", "wrapped pointers", fetch(9'h1FD, 4), ref_madd(a, b, p));
  endtask

  task automatic t_disturb();
    logic [BW-1:0] a, b, p;
    int cyc;
    gen_mod(8, p);
    gen_below(8, p, a); gen_below(8, p, b);
    load(PA, 8, a); load(PB, 8, b); load(PP, 8, p);
    run(3'd3, 7, PA, PB, PP, PC, 1'b1, cyc);
    chk("R11", "disturbed inputs result", fetch(PC, 8), ref_msub(a, b, p));
    chk("R11", "disturbed inputs latency", BW'(cyc), BW'((a >= b) ? 24 : 48));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_madd();
    t_msub();
    t_shl();
    t_cmp();
    t_badd();
    t_wrap();
    t_disturb();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule